// File: doc/BRIEF.md
# Shared Timer Prescaler With Per-Timer Clock Select

This block supplies count-enable pulses to a group of timers (two by default) from one free-running divider. Each timer has its own 3-bit select code. The code picks what drives that timer's tick. The timer can be halted, stepped on every system clock, stepped at one of four divided rates taken from the shared divider, or stepped by edges on its own external pin. Each timer owns one pin.

The divided rates are taps on a single 10-bit counter. That counter advances on every clock. A divided tick is a one-cycle pulse in the cycle where the counter's low bits are all ones. Every timer that selects the same rate therefore ticks in the same cycle. A single-cycle clear strobe zeroes the shared counter. This restarts the phase of every divided rate for all timers together.

External pins are asynchronous. Each pin passes through a two-flop synchroniser and then an edge detector. An edge is seen at the pin before clock edge k, and the matching tick is high in the cycle between clock edges k+1 and k+2.

Top module: `psc_shared_prescaler`

## Requirements
- R1: Select code 000 keeps that timer's tick low, whatever the divider and the pin are doing.
- R2: Select code 001 holds that timer's tick high in every cycle.
- R3: Select code 010 ticks once every 8 clocks. The tick is high in the cycle where bits [2:0] of the shared counter equal 7. The counter is 0 in the first cycle after reset and advances by one per clock.
- R4: Select codes 011, 100 and 101 tick once every 64, 256 and 1024 clocks. The tick is high when the counter's low 6, 8 or all 10 bits are all ones.
- R5: Select code 110 gives one tick for each falling edge of that timer's pin. The tick is high in the cycle between the second and third clock edges after the pin changes.
- R6: Select code 111 gives one tick for each rising edge of that timer's pin, with the same latency as R5.
- R7: A high clear strobe at a clock edge sets the shared counter to 0 for that next cycle. This restarts the divided ticks of all timers at once. A low strobe changes nothing.
- R8: Every divided or edge tick lasts exactly one cycle, even when the pin toggles on every clock.
- R9: Each timer's tick depends only on its own select code and its own pin, plus the shared counter.
- R10: The shared counter wraps from 1023 to 0 with no gap, so the divide-by-1024 rate stays periodic across the wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Single-cycle strobe that zeroes the shared divider |
| sel_i | input | 3*N_TIMERS | Select codes; timer t uses bits [3t+2:3t] |
| ext_pin_i | input | N_TIMERS | Asynchronous external count inputs, one per timer |
| tick_o | output | N_TIMERS | Count-enable pulse for each timer |

## Verification
The bench goes after the phase of the divided ticks right after reset, right after a clear strobe and across the counter wrap. A divider that is off by one, that ignores the clear or that skips a value at the wrap would tick a cycle early or late, and the per-cycle compare would catch it. It toggles pins on every clock and at wider gaps under both edge codes. A swapped edge polarity would tick on the wrong transitions, a missing synchroniser stage would tick a cycle early, and a level detector would stretch the pulses. It also toggles the pins while code 000 is selected, where a leak through the select logic would show as a stray tick.

// File: rtl/psc_pkg.sv
package psc_pkg;

   typedef enum logic [2:0] {
      SEL_OFF      = 3'b000,
      SEL_CLK      = 3'b001,
      SEL_D8       = 3'b010,
      SEL_D64      = 3'b011,
      SEL_D256     = 3'b100,
      SEL_D1024    = 3'b101,
      SEL_EXT_FALL = 3'b110,
      SEL_EXT_RISE = 3'b111
   } psc_sel_e;

   localparam int unsigned SEL_W    = 3;
   localparam int unsigned NUM_TAPS = 4;

   // number of low counter bits that must be ones for each tap
   function automatic int unsigned tap_bits(input int unsigned idx);
      case (idx)
         0:       return 3;
         1:       return 6;
         2:       return 8;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/psc_divider.sv
module psc_divider
   import psc_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clear_i,
   output logic [NUM_TAPS-1:0] tap_o
);

   initial begin
      if (CNT_W < tap_bits(NUM_TAPS-1))
         $error("psc_divider: CNT_W too small for the widest tap");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
   end

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      localparam int unsigned B = tap_bits(t);
      assign tap_o[t] = &cnt_q[B-1:0];
   end

   // R7
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> cnt_q == '0);

   // R10
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> cnt_q == $past(cnt_q) + 1'b1);

   // R8
   tap_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tap_o[0] |=> !tap_o[0]);

endmodule

// File: rtl/psc_ext_edge.sv
module psc_ext_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);

   initial begin
      if (SYNC_STAGES < 2)
         $error("psc_ext_edge: at least two synchroniser stages are needed");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   synced;

   assign synced = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         prev_q <= synced;
      end
   end

   assign rise_o = synced & ~prev_q;
   assign fall_o = ~synced & prev_q;

   // R8
   rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

   // R8
   fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);

endmodule

// File: rtl/psc_tick_sel.sv
module psc_tick_sel
   import psc_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic [NUM_TAPS-1:0] tap_i,
   input  logic                rise_i,
   input  logic                fall_i,
   output logic                tick_o
);

   psc_sel_e sel;
   assign sel = psc_sel_e'(sel_i);

   always_comb begin
      unique case (sel)
         SEL_OFF:      tick_o = 1'b0;
         SEL_CLK:      tick_o = 1'b1;
         SEL_D8:       tick_o = tap_i[0];
         SEL_D64:      tick_o = tap_i[1];
         SEL_D256:     tick_o = tap_i[2];
         SEL_D1024:    tick_o = tap_i[3];
         SEL_EXT_FALL: tick_o = fall_i;
         SEL_EXT_RISE: tick_o = rise_i;
         default:      tick_o = 1'b0;
      endcase
   end

   // R1
   off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel == SEL_OFF |-> !tick_o);

   // R2
   clk_every_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel == SEL_CLK |-> tick_o);

   // R8
   div_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && sel inside {SEL_D8, SEL_D64, SEL_D256, SEL_D1024})
      |=> (!tick_o || !$stable(sel_i)));

endmodule

// File: rtl/psc_shared_prescaler.sv
module psc_shared_prescaler
   import psc_pkg::*;
#(
   parameter int unsigned N_TIMERS    = 2,
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clear_i,
   input  logic [SEL_W*N_TIMERS-1:0] sel_i,
   input  logic [N_TIMERS-1:0]       ext_pin_i,
   output logic [N_TIMERS-1:0]       tick_o
);

   initial begin
      if (N_TIMERS < 1)
         $error("psc_shared_prescaler: N_TIMERS must be at least 1");
   end

   logic [NUM_TAPS-1:0] tap;

   psc_divider #(.CNT_W(CNT_W)) i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_i),
      .tap_o   (tap)
   );

   for (genvar t = 0; t < N_TIMERS; t++) begin : g_timer
      logic rise, fall;

      psc_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (ext_pin_i[t]),
         .rise_o (rise),
         .fall_o (fall)
      );

      psc_tick_sel i_sel (
         .clk    (clk),
         .rst_n  (rst_n),
         .sel_i  (sel_i[t*SEL_W +: SEL_W]),
         .tap_i  (tap),
         .rise_i (rise),
         .fall_i (fall),
         .tick_o (tick_o[t])
      );
   end

endmodule

// File: tb/test_psc_shared_prescaler.sv
`timescale 1ns/1ps
module test_psc_shared_prescaler;

   localparam int NT = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clear = 1'b0;
   logic [3*NT-1:0] sel = '0;
   logic [NT-1:0] pin = '0;
   logic [NT-1:0] tick;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit mon_en = 1'b0;
   bit done = 1'b0;
   logic [9:0] ref_cnt = '0;
   string phase = "R1";

   // scoreboard queues: cycles at which an edge tick is expected
   int rise_q[NT][$];
   int fall_q[NT][$];

   always #2.5 clk = ~clk;

   psc_shared_prescaler i_psc_shared_prescaler (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear),
      .sel_i     (sel),
      .ext_pin_i (pin),
      .tick_o    (tick)
   );

   // reference divider count per R3, R7 and R10
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (!rst_n || clear) ref_cnt <= '0;
      else                 ref_cnt <= ref_cnt + 1'b1;
   end

   // monitor
   always @(negedge clk) begin
      #1;
      if (mon_en) begin
         for (int t = 0; t < NT; t++) begin
            bit r_hit, f_hit, exp;
            string req;
            logic [2:0] code;
            r_hit = 0; f_hit = 0;
            while (rise_q[t].size() > 0 && rise_q[t][0] < cyc) void'(rise_q[t].pop_front());
            while (fall_q[t].size() > 0 && fall_q[t][0] < cyc) void'(fall_q[t].pop_front());
            if (rise_q[t].size() > 0 && rise_q[t][0] == cyc) begin r_hit = 1; void'(rise_q[t].pop_front()); end
            if (fall_q[t].size() > 0 && fall_q[t][0] == cyc) begin f_hit = 1; void'(fall_q[t].pop_front()); end
            code = sel[t*3 +: 3];
            case (code)
               3'd0: begin exp = 0;                   req = "R1"; end
               3'd1: begin exp = 1;                   req = "R2"; end
               3'd2: begin exp = (ref_cnt[2:0] == 3'h7); req = "R3"; end
               3'd3: begin exp = (ref_cnt[5:0] == 6'h3f); req = "R4"; end
               3'd4: begin exp = (ref_cnt[7:0] == 8'hff); req = "R4"; end
               3'd5: begin exp = (ref_cnt == 10'h3ff); req = "R4"; end
               3'd6: begin exp = f_hit;               req = "R5"; end
               default: begin exp = r_hit;            req = "R6"; end
            endcase
            checks++;
            if (tick[t] !== exp) begin
               errors++;
               $display("FAIL %s (%s) timer %0d cycle %0d sel %b: tick actual %b expected %b",
                        req, phase, t, cyc, code, tick[t], exp);
            end
         end
      end
   end

   task automatic set_sel(input int t, input logic [2:0] code);
      sel[t*3 +: 3] = code;
   endtask

   // toggle a pin at this negedge; the tick shows two clock edges later
   task automatic toggle_pin(input int t);
      pin[t] = ~pin[t];
      if (pin[t]) rise_q[t].push_back(cyc + 2);
      else        fall_q[t].push_back(cyc + 2);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_clear;
      @(negedge clk);
      clear = 1'b1;
      @(negedge clk);
      clear = 1'b0;
   endtask

   initial begin
      idle(5);
      rst_n = 1'b1;
      mon_en = 1'b1;
      // R1: both timers halted
      phase = "R1";
      idle(20);
      // R2, R3 and R9: different selects side by side
      @(negedge clk);
      phase = "R2/R3/R9";
      set_sel(0, 3'b001); set_sel(1, 3'b010);
      idle(40);
      // R4 with R7: clear strobe in the middle
      phase = "R4/R7";
      set_sel(0, 3'b011); set_sel(1, 3'b100);
      idle(300);
      pulse_clear();
      idle(300);
      // R10: divide by 1024 across two wraps
      phase = "R4/R10";
      set_sel(0, 3'b101); set_sel(1, 3'b010);
      idle(2200);
      pulse_clear();
      idle(3);
      // R5, R6 and R8: edges with gaps and on every clock
      phase = "R5/R6/R8";
      set_sel(0, 3'b111); set_sel(1, 3'b110);
      for (int k = 0; k < 6; k++) begin
         toggle_pin(0); toggle_pin(1);
         idle(5);
      end
      for (int k = 0; k < 10; k++) begin
         toggle_pin(0); toggle_pin(1);
         idle(1);
      end
      idle(6);
      set_sel(0, 3'b110); set_sel(1, 3'b111);
      for (int k = 0; k < 8; k++) begin
         toggle_pin(0);
         idle(k % 3 + 1);
         toggle_pin(1);
         idle(2);
      end
      idle(6);
      // R1: pins ignored while halted
      phase = "R1 pins";
      set_sel(0, 3'b000); set_sel(1, 3'b000);
      for (int k = 0; k < 6; k++) begin
         toggle_pin(0); toggle_pin(1);
         idle(3);
      end
      idle(6);
      mon_en = 1'b0;
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual still running, expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule